// File: doc/BRIEF.md
# Partitioned Data Scratchpad with Frame-Save Region

This block is a 1536-byte on-chip data memory that starts at byte address 0 of the memory map. A boundary register, written by software, divides the array into two parts. The low part is kept for the procedure-call machinery, which saves and restores register frames there. The high part serves as ordinary data storage for the core's loads and stores.

There are two ports. The frame port moves whole 128-bit quads and may touch only the low part. The general port performs 32-bit word or 128-bit quad loads and stores in the high part, and it refuses instruction fetches. Every accepted access finishes in one clock. Read data, the acknowledge and the fault flags appear in the cycle after the request. When both ports ask in the same cycle, the frame port is served and the general port is held off for that cycle.

Top module: `dsram_top`

## Requirements
- R1: After reset the boundary is 0 frames. Every acknowledge and fault output is low, and `genStall` is low while no request is present.
- R2: A `cfgWe` pulse loads `cfgFrames` into the boundary, which takes effect in the next cycle and is reported on `partFrames`. A value above 24 is clamped to 24. One frame is 64 bytes, so the boundary byte address is `partFrames`*64.
- R3: A general word access (`genQuad`=0) at a 4-byte-aligned address between the boundary and 1535 is acknowledged one cycle later. A store writes `genWdata[31:0]` to that word. A load returns the word in `genRdata[31:0]` with the upper 96 bits zero.
- R4: A general quad access (`genQuad`=1) at a 16-byte-aligned address moves four words in one cycle. Lane i, at bits [32i+31:32i], is the word at byte address addr+4i.
- R5: A general access below the boundary raises `genFault` one cycle later. It does not write, does not acknowledge and returns zero data.
- R6: A general access at byte address 1536 or above faults in the same way as R5.
- R7: A word access with addr[1:0]≠0, or a quad access with addr[3:0]≠0, faults as in R5 and leaves memory unchanged.
- R8: A general request with `genFetch`=1 raises `genFetchFault` one cycle later at any address. It returns zero, never writes, and does not raise `genFault` or `genAck`.
- R9: A frame-port quad access at a 16-byte-aligned address below the boundary is acknowledged one cycle later and reads or writes all four lanes as in R4. If the address is at or above the boundary, or is misaligned, the access raises `frmFault`, does not write and returns zero.
- R10: When `frmReq` and `genReq` are both high, `genStall` is high in that cycle. The frame access is performed. The general access is dropped: it gets no acknowledge or fault and makes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Load the boundary register |
| cfgFrames | input | 5 | New boundary in 64-byte frames |
| partFrames | output | 5 | Current boundary in frames |
| frmReq | input | 1 | Frame-port request |
| frmWe | input | 1 | Frame-port store |
| frmAddr | input | 11 | Frame-port byte address |
| frmWdata | input | 128 | Frame-port store quad |
| frmAck | output | 1 | Frame access done (previous cycle) |
| frmFault | output | 1 | Frame access refused (previous cycle) |
| frmRdata | output | 128 | Frame-port load quad |
| genReq | input | 1 | General-port request |
| genWe | input | 1 | General-port store |
| genQuad | input | 1 | 1 = quad, 0 = word |
| genFetch | input | 1 | Request is an instruction fetch |
| genAddr | input | 11 | General-port byte address |
| genWdata | input | 128 | General store data (word in bits 31:0) |
| genStall | output | 1 | General request not taken this cycle |
| genAck | output | 1 | General access done (previous cycle) |
| genFault | output | 1 | General access refused (previous cycle) |
| genFetchFault | output | 1 | Fetch refused (previous cycle) |
| genRdata | output | 128 | General-port load data |

## Verification
The bench first fills the frame region through the frame port under a 2-frame boundary. It then sweeps every word address of the general port for stores and for loads, so both sides of the boundary and the region past 1536 are covered. Misaligned word and quad stores, fetch-flavoured stores spread over the whole address range, and a store that collides with a frame access are then applied at addresses whose contents are known. A final quad read sweep with the boundary at zero checks each of these cases. It separates a dropped or refused store from one that landed, and shows frame-port data from general-port data, lane by lane. Setting the boundary to 31 shows that the value is clamped to 24 and that the whole array is then closed to the general port.

// File: rtl/dsram_pkg.sv
package dsram_pkg;
  // Strobes from the control to the datapath; at most one port touches the array per cycle
  typedef struct packed {
    logic frmRd;
    logic frmWr;
    logic genRd;
    logic genWr;
    logic genQuad;
  } dsramStrobe_t;
endpackage

// File: rtl/dsram_ctrl.sv
module dsram_ctrl
  import dsram_pkg::*;
#(
  parameter int MEM_BYTES   = 1536,
  parameter int FRAME_BYTES = 64,
  parameter int WORD_W      = 32,
  parameter int ADDR_W      = 11,
  localparam int MAX_FRAMES = MEM_BYTES / FRAME_BYTES,
  localparam int PART_W     = $clog2(MAX_FRAMES + 1),
  localparam int QUAD_BYTES = 4 * WORD_W / 8,
  localparam int QB_W       = $clog2(QUAD_BYTES),
  localparam int WB_W       = $clog2(WORD_W / 8),
  localparam int NUM_ROWS   = MEM_BYTES / QUAD_BYTES,
  localparam int ROW_W      = $clog2(NUM_ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [PART_W-1:0] cfgFrames,
  output logic [PART_W-1:0] partFrames,
  input  logic              frmReq,
  input  logic              frmWe,
  input  logic [ADDR_W-1:0] frmAddr,
  input  logic              genReq,
  input  logic              genWe,
  input  logic              genQuad,
  input  logic              genFetch,
  input  logic [ADDR_W-1:0] genAddr,
  output logic              genStall,
  output logic              genAck,
  output logic              genFault,
  output logic              genFetchFault,
  output logic              frmAck,
  output logic              frmFault,
  output dsramStrobe_t      stb,
  output logic [ROW_W-1:0]  row,
  output logic [1:0]        lane
);
  localparam logic [ADDR_W:0] MEM_END = (ADDR_W+1)'(MEM_BYTES);

  logic [PART_W-1:0] partQ;
  logic [ADDR_W:0]   boundByte;
  logic genGo, genMis, genOutside, genOk, genBad, fetchHit;
  logic frmMis, frmOutside, frmOk, frmBad;

  // Boundary register with clamp
  always_ff @(posedge clk) begin
    if (!rstN)      partQ <= '0;
    else if (cfgWe) partQ <= (cfgFrames > PART_W'(MAX_FRAMES)) ? PART_W'(MAX_FRAMES) : cfgFrames;
  end
  assign partFrames = partQ;
  assign boundByte  = (ADDR_W+1)'(partQ) * (ADDR_W+1)'(FRAME_BYTES);

  // Arbitration: frame port wins
  assign genStall = genReq && frmReq;
  assign genGo    = genReq && !frmReq;

  // General-port decode
  assign genMis     = genQuad ? (|genAddr[QB_W-1:0]) : (|genAddr[WB_W-1:0]);
  assign genOutside = ({1'b0, genAddr} < boundByte) || ({1'b0, genAddr} >= MEM_END);
  assign fetchHit   = genGo && genFetch;
  assign genOk      = genGo && !genFetch && !genMis && !genOutside;
  assign genBad     = genGo && !genFetch && (genMis || genOutside);

  // Frame-port decode
  assign frmMis     = |frmAddr[QB_W-1:0];
  assign frmOutside = {1'b0, frmAddr} >= boundByte;
  assign frmOk      = frmReq && !frmMis && !frmOutside;
  assign frmBad     = frmReq && (frmMis || frmOutside);

  always_comb begin
    stb.frmRd   = frmOk && !frmWe;
    stb.frmWr   = frmOk && frmWe;
    stb.genRd   = genOk && !genWe;
    stb.genWr   = genOk && genWe;
    stb.genQuad = genQuad;
    row  = frmReq ? frmAddr[QB_W +: ROW_W] : genAddr[QB_W +: ROW_W];
    lane = genAddr[WB_W +: 2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      genAck <= 1'b0; genFault <= 1'b0; genFetchFault <= 1'b0;
      frmAck <= 1'b0; frmFault <= 1'b0;
    end else begin
      genAck        <= genOk;
      genFault      <= genBad;
      genFetchFault <= fetchHit;
      frmAck        <= frmOk;
      frmFault      <= frmBad;
    end
  end

  // A stalled general request produces no response next cycle
  assert_stall_drops_R10: assert property (@(posedge clk) disable iff (!rstN)
    genStall |=> (!genAck && !genFault && !genFetchFault));
  // General responses are mutually exclusive
  assert_resp_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({genAck, genFault, genFetchFault}));
  // Boundary never exceeds the array
  assert_part_clamp_R2: assert property (@(posedge clk) disable iff (!rstN)
    partQ <= PART_W'(MAX_FRAMES));
  // Frame responses are exclusive
  assert_frm_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(frmAck && frmFault));
endmodule

// File: rtl/dsram_datapath.sv
module dsram_datapath
  import dsram_pkg::*;
#(
  parameter int MEM_BYTES = 1536,
  parameter int WORD_W    = 32,
  localparam int QUAD_W   = 4 * WORD_W,
  localparam int NUM_ROWS = MEM_BYTES / (QUAD_W / 8),
  localparam int ROW_W    = $clog2(NUM_ROWS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dsramStrobe_t       stb,
  input  logic [ROW_W-1:0]   row,
  input  logic [1:0]         lane,
  input  logic [QUAD_W-1:0]  frmWdata,
  input  logic [QUAD_W-1:0]  genWdata,
  output logic [QUAD_W-1:0]  frmRdata,
  output logic [QUAD_W-1:0]  genRdata
);
  logic [3:0][WORD_W-1:0] rowWords;
  logic [QUAD_W-1:0]      genLoad;

  // One storage column per 32-bit lane
  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [WORD_W-1:0] laneMem [NUM_ROWS];
    always_ff @(posedge clk) begin
      if (stb.frmWr)
        laneMem[row] <= frmWdata[l*WORD_W +: WORD_W];
      else if (stb.genWr && stb.genQuad)
        laneMem[row] <= genWdata[l*WORD_W +: WORD_W];
      else if (stb.genWr && (lane == 2'(l)))
        laneMem[row] <= genWdata[WORD_W-1:0];
    end
    assign rowWords[l] = laneMem[row];
  end

  assign genLoad = stb.genQuad ? rowWords : {{(QUAD_W-WORD_W){1'b0}}, rowWords[lane]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmRdata <= '0;
      genRdata <= '0;
    end else begin
      frmRdata <= stb.frmRd ? rowWords : '0;
      genRdata <= stb.genRd ? genLoad : '0;
    end
  end

  // At most one port uses the array per cycle
  assert_one_user_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.frmRd, stb.frmWr, stb.genRd, stb.genWr}));
  // No write ever lands beyond the array
  assert_row_in_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frmWr || stb.genWr) |-> ({1'b0, row} < (ROW_W+1)'(NUM_ROWS)));
endmodule

// File: rtl/dsram_top.sv
module dsram_top
  import dsram_pkg::*;
#(
  parameter int MEM_BYTES   = 1536,
  parameter int FRAME_BYTES = 64,
  parameter int WORD_W      = 32,
  parameter int ADDR_W      = 11,
  localparam int PART_W     = $clog2(MEM_BYTES / FRAME_BYTES + 1),
  localparam int QUAD_W     = 4 * WORD_W,
  localparam int ROW_W      = $clog2(MEM_BYTES / (QUAD_W / 8))
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [PART_W-1:0] cfgFrames,
  output logic [PART_W-1:0] partFrames,
  input  logic              frmReq,
  input  logic              frmWe,
  input  logic [ADDR_W-1:0] frmAddr,
  input  logic [QUAD_W-1:0] frmWdata,
  output logic              frmAck,
  output logic              frmFault,
  output logic [QUAD_W-1:0] frmRdata,
  input  logic              genReq,
  input  logic              genWe,
  input  logic              genQuad,
  input  logic              genFetch,
  input  logic [ADDR_W-1:0] genAddr,
  input  logic [QUAD_W-1:0] genWdata,
  output logic              genStall,
  output logic              genAck,
  output logic              genFault,
  output logic              genFetchFault,
  output logic [QUAD_W-1:0] genRdata
);
  dsramStrobe_t     stb;
  logic [ROW_W-1:0] row;
  logic [1:0]       lane;

  dsram_ctrl #(.MEM_BYTES(MEM_BYTES), .FRAME_BYTES(FRAME_BYTES), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgFrames(cfgFrames), .partFrames(partFrames),
    .frmReq(frmReq), .frmWe(frmWe), .frmAddr(frmAddr),
    .genReq(genReq), .genWe(genWe), .genQuad(genQuad), .genFetch(genFetch), .genAddr(genAddr),
    .genStall(genStall), .genAck(genAck), .genFault(genFault), .genFetchFault(genFetchFault),
    .frmAck(frmAck), .frmFault(frmFault), .stb(stb), .row(row), .lane(lane));

  dsram_datapath #(.MEM_BYTES(MEM_BYTES), .WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .row(row), .lane(lane),
    .frmWdata(frmWdata), .genWdata(genWdata), .frmRdata(frmRdata), .genRdata(genRdata));

  // Refused fetches return zero data
  assert_fetch_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    genFetchFault |-> (genRdata == '0));
  // Refused general accesses return zero data
  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    genFault |-> (genRdata == '0));
  // Refused frame accesses return zero data
  assert_frm_fault_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    frmFault |-> (frmRdata == '0));
endmodule

// File: tb/dsram_top_tb_top.sv
module dsram_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [4:0] cfgFrames = '0;
  logic [4:0] partFrames;
  logic frmReq = 1'b0, frmWe = 1'b0;
  logic [10:0] frmAddr = '0;
  logic [127:0] frmWdata = '0, frmRdata;
  logic frmAck, frmFault;
  logic genReq = 1'b0, genWe = 1'b0, genQuad = 1'b0, genFetch = 1'b0;
  logic [10:0] genAddr = '0;
  logic [127:0] genWdata = '0, genRdata;
  logic genStall, genAck, genFault, genFetchFault;

  int checks = 0;
  int fails = 0;
  logic [31:0] model [384];

  always #10 clk = ~clk;

  dsram_top dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgFrames(cfgFrames), .partFrames(partFrames),
    .frmReq(frmReq), .frmWe(frmWe), .frmAddr(frmAddr), .frmWdata(frmWdata),
    .frmAck(frmAck), .frmFault(frmFault), .frmRdata(frmRdata),
    .genReq(genReq), .genWe(genWe), .genQuad(genQuad), .genFetch(genFetch),
    .genAddr(genAddr), .genWdata(genWdata), .genStall(genStall), .genAck(genAck),
    .genFault(genFault), .genFetchFault(genFetchFault), .genRdata(genRdata));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit gFault(input int a, input bit q, input int part);
    return (q ? (a % 16 != 0) : (a % 4 != 0)) || (a < part * 64) || (a >= 1536);
  endfunction

  function automatic logic [127:0] quadOf(input int r);
    return {model[r*4+3], model[r*4+2], model[r*4+1], model[r*4]};
  endfunction

  task automatic setPart(input int f);
    @(negedge clk); cfgWe = 1'b1; cfgFrames = 5'(f);
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic genOp(input bit we, input bit q, input bit f, input int a, input logic [127:0] wd);
    @(negedge clk);
    genReq = 1'b1; genWe = we; genQuad = q; genFetch = f; genAddr = 11'(a); genWdata = wd;
    @(negedge clk);
    genReq = 1'b0; genWe = 1'b0; genFetch = 1'b0;
  endtask

  task automatic frmOp(input bit we, input int a, input logic [127:0] wd);
    @(negedge clk);
    frmReq = 1'b1; frmWe = we; frmAddr = 11'(a); frmWdata = wd;
    @(negedge clk);
    frmReq = 1'b0; frmWe = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [127:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(partFrames == 0, "R1 partFrames", 128'(partFrames), 0);
    chk({genAck, genFault, genFetchFault, frmAck, frmFault, genStall} == 0, "R1 flags",
        128'({genAck, genFault, genFetchFault, frmAck, frmFault, genStall}), 0);

    // R2 boundary = 2 frames (128 bytes)
    setPart(2);
    chk(partFrames == 2, "R2 load", 128'(partFrames), 2);

    // R9 frame-port fill of rows 0..7
    for (int r = 0; r < 8; r++) begin
      for (int l = 0; l < 4; l++) model[r*4+l] = 32'hF0000000 | 32'(r*4+l);
      frmOp(1'b1, r*16, quadOf(r));
      chk(frmAck && !frmFault, "R9 frame write ack", 128'({frmAck, frmFault}), 2);
    end
    frmOp(1'b1, 128, '1);
    chk(frmFault && !frmAck, "R9 frame above boundary", 128'({frmAck, frmFault}), 1);
    frmOp(1'b1, 36, '1);
    chk(frmFault && !frmAck, "R9 frame misaligned", 128'({frmAck, frmFault}), 1);
    frmOp(1'b0, 48, '0);
    chk(frmRdata == quadOf(3) && frmAck, "R9 frame read", frmRdata, quadOf(3));

    // R3/R5 word store sweep across the whole array
    for (int a = 0; a < 1536; a += 4) begin
      bit ef;
      ef = gFault(a, 1'b0, 2);
      if (!ef) model[a/4] = 32'h5A000000 | 32'(a * 7);
      genOp(1'b1, 1'b0, 1'b0, a, {96'h0, 32'h5A000000 | 32'(a * 7)});
      chk(genAck == !ef && genFault == ef, ef ? "R5 word store below boundary" : "R3 word store",
          128'({genAck, genFault}), 128'({!ef, ef}));
    end
    // R3/R5 word load sweep
    for (int a = 0; a < 1536; a += 4) begin
      bit ef;
      ef = gFault(a, 1'b0, 2);
      genOp(1'b0, 1'b0, 1'b0, a, '0);
      d = ef ? 128'h0 : {96'h0, model[a/4]};
      chk(genRdata == d && genFault == ef && genAck == !ef, ef ? "R5 word load below boundary" : "R3 word load", genRdata, d);
    end
    // R6 past the end
    for (int a = 1536; a < 2048; a += 4) begin
      genOp(1'b1, a[4], 1'b0, a & ~(a[4] ? 15 : 0), '1);
      chk(genFault && !genAck && genRdata == 0, "R6 out of range", 128'({genAck, genFault}), 1);
    end
    // R7 misaligned word and quad stores
    for (int k = 1; k < 16; k++) begin
      genOp(1'b1, 1'b0, 1'b0, 512 + k, '1);
      chk(genFault == (k % 4 != 0) && genAck == (k % 4 == 0), "R7 word alignment",
          128'({genAck, genFault}), 128'({k % 4 == 0, k % 4 != 0}));
      if (k % 4 == 0) model[(512 + k) / 4] = '1;
      genOp(1'b1, 1'b1, 1'b0, 768 + k, '1);
      chk(genFault && !genAck, "R7 quad misaligned", 128'({genAck, genFault}), 1);
    end
    // R4 quad stores rows 40..47
    for (int r = 40; r < 48; r++) begin
      for (int l = 0; l < 4; l++) model[r*4+l] = 32'h3C000000 | 32'(r * 16 + l * 3);
      genOp(1'b1, 1'b1, 1'b0, r * 16, quadOf(r));
      chk(genAck && !genFault, "R4 quad store", 128'({genAck, genFault}), 2);
    end
    // R8 fetches, with store attempted, all over the range
    for (int a = 0; a < 2048; a += 52) begin
      genOp(1'b1, a[3], 1'b1, a, '1);
      chk(genFetchFault && !genFault && !genAck && genRdata == 0, "R8 fetch refused",
          128'({genFetchFault, genFault, genAck}), 4);
    end
    // R10 collision: frame read row 1 with a general store to 1024
    @(negedge clk);
    frmReq = 1'b1; frmWe = 1'b0; frmAddr = 11'd16;
    genReq = 1'b1; genWe = 1'b1; genQuad = 1'b0; genAddr = 11'd1024; genWdata = '1;
    #1 chk(genStall, "R10 stall raised", 128'(genStall), 1);
    @(negedge clk);
    frmReq = 1'b0; genReq = 1'b0; genWe = 1'b0;
    chk(frmAck && frmRdata == quadOf(1), "R10 frame served", frmRdata, quadOf(1));
    chk(!genAck && !genFault, "R10 general dropped", 128'({genAck, genFault}), 0);

    // Boundary 0: quad read sweep verifies every stored and refused write (R4 R5 R7 R8 R9 R10)
    setPart(0);
    for (int r = 0; r < 96; r++) begin
      genOp(1'b0, 1'b1, 1'b0, r * 16, '0);
      chk(genAck && genRdata == quadOf(r), "R4 quad load / contents", genRdata, quadOf(r));
    end
    // R2 clamp
    setPart(31);
    chk(partFrames == 24, "R2 clamp", 128'(partFrames), 24);
    genOp(1'b0, 1'b0, 1'b0, 1532, '0);
    chk(genFault && !genAck, "R5 whole array closed", 128'({genAck, genFault}), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule